// File: doc/BRIEF.md
# Test-Access Instruction Register with Decoder

This block holds the instruction for a boundary-scan test port. It has a serial stage that takes a fixed pattern on capture, shifts it out least-significant bit first while new bits arrive from the serial data input, and a shadow stage that takes the shifted value only when the update enable is pulsed. The shadow stage drives the decoded controls, so shifting never disturbs the test that is running.

The decoder handles the minimum instruction set: external test, sample/preload, identification, and bypass. It produces a two-bit select code that steers the serial output mux between the bypass, boundary and identification registers. It also produces the boundary mode signal, which hands the output pads to the boundary update stages. A controller outside the block supplies the capture, shift and update enables, all sampled on the rising test clock. Test reset is asynchronous and active low.

Top module: `tap_instr_reg`

## Requirements
- R1: While test reset is low, and after it is released, the latched instruction is the identification code 0...01. With the default setup it decodes to select code 2'b10.
- R2: A capture loads 2'b01 into the two low bits of the serial stage and the status inputs into the upper bits. Status bits [1:0] have no effect.
- R3: The serial output always shows bit 0 of the serial stage. Each shift moves the stage one place toward bit 0 and loads the serial data input into the top bit. A captured value therefore leaves as 1 first, then 0.
- R4: The latched instruction changes only on a clock edge where the update enable is high. Shifting and capturing leave it and the decoded outputs untouched.
- R5: Code all-zeros (external test) gives select 2'b01 (boundary) and boundary mode 1.
- R6: Code 0...010 (sample/preload) gives select 2'b01 with boundary mode 0.
- R7: Code 0...01 (identification) gives select 2'b10 with boundary mode 0 when the identification register is present. When it is absent, the code gives select 2'b00.
- R8: Code all-ones, and every unassigned code, gives select 2'b00 (bypass) with boundary mode 0.
- R9: When capture and shift are both high on one edge, the capture wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock, rising edge active |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial data into the top bit of the serial stage |
| cap_en | input | 1 | Load the capture pattern into the serial stage |
| shf_en | input | 1 | Shift the serial stage toward bit 0 |
| upd_en | input | 1 | Copy the serial stage into the shadow stage |
| status_in | input | IR_W | Status bits captured into bits IR_W-1..2; bits 1..0 unused |
| ir_so | output | 1 | Serial output, bit 0 of the serial stage |
| instr | output | IR_W | Latched instruction from the shadow stage |
| reg_sel | output | 2 | Serial output mux select: 00 bypass, 01 boundary, 10 identification |
| bs_mode | output | 1 | Boundary mode: 1 lets update stages drive the pads |

## Verification
The embedded properties check on every cycle that the latched instruction holds when no update occurs, that a capture always presents a 1 on the serial output, that boundary mode never occurs without the boundary select, and that all-ones decodes to bypass. Only the bench scenarios can show the full decode table at two widths, the order of shifted-out bits, status placement, the absent-identification variant, capture priority, and that a mid-run reset restores the identification code.

// File: rtl/tap_instr_reg.sv
module tap_instr_reg #(
  parameter int IR_W   = 2,
  parameter bit HAS_ID = 1'b1
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            cap_en,
  input  logic            shf_en,
  input  logic            upd_en,
  input  logic [IR_W-1:0] status_in,
  output logic            ir_so,
  output logic [IR_W-1:0] instr,
  output logic [1:0]      reg_sel,
  output logic            bs_mode
);

  localparam logic [IR_W-1:0] OP_EXT = '0;
  localparam logic [IR_W-1:0] OP_ID  = IR_W'(1);
  localparam logic [IR_W-1:0] OP_SMP = IR_W'(2);
  localparam logic [IR_W-1:0] OP_BYP = '1;
  localparam logic [1:0] SEL_BYP = 2'b00;
  localparam logic [1:0] SEL_BSR = 2'b01;
  localparam logic [1:0] SEL_ID  = 2'b10;
  localparam logic [1:0] SEL_IDC = HAS_ID ? SEL_ID : SEL_BYP;

  logic [IR_W-1:0] sh_q;
  logic [IR_W-1:0] cap_val;
  logic            unused_stat;

  assign unused_stat = ^status_in[1:0];

  generate
    if (IR_W > 2) begin : g_stat
      assign cap_val = {status_in[IR_W-1:2], 2'b01};
    end else begin : g_nostat
      assign cap_val = 2'b01;
    end
  endgenerate

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      sh_q <= OP_ID;
    else if (cap_en)  sh_q <= cap_val;
    else if (shf_en)  sh_q <= {tdi, sh_q[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      instr <= OP_ID;
    else if (upd_en)  instr <= sh_q;
  end

  assign ir_so = sh_q[0];

  always_comb begin
    reg_sel = SEL_BYP;
    bs_mode = 1'b0;
    case (instr)
      OP_EXT: begin reg_sel = SEL_BSR; bs_mode = 1'b1; end
      OP_SMP: reg_sel = SEL_BSR;
      OP_ID:  reg_sel = SEL_IDC;
      default: reg_sel = SEL_BYP;
    endcase
  end

  a_r1_reset_idcode: assert property (@(posedge tck) $rose(trst_n) |-> instr == OP_ID);
  a_r2_capture_lsb: assert property (@(posedge tck) disable iff (!trst_n) cap_en |=> ir_so);
  a_r4_hold_no_update: assert property (@(posedge tck) disable iff (!trst_n) !upd_en |=> $stable(instr));
  a_r5_mode_needs_bsr: assert property (@(posedge tck) disable iff (!trst_n) bs_mode |-> reg_sel == SEL_BSR);
  a_r8_ones_bypass: assert property (@(posedge tck) disable iff (!trst_n)
    (instr == OP_BYP) |-> (reg_sel == SEL_BYP && !bs_mode));

endmodule

// File: tb/tap_instr_reg_tb.sv
module tap_instr_reg_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tdi = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0;
  logic [1:0] st2 = 2'b00;
  logic [3:0] st4 = 4'b0000;
  logic so2, md2, so4, md4, son, mdn;
  logic [1:0] ins2, sel2, sel4, insn, seln;
  logic [3:0] ins4;
  int nchk = 0, nerr = 0;

  always #2 clk = ~clk;

  tap_instr_reg #(.IR_W(2), .HAS_ID(1'b1)) u_dut (.tck(clk), .trst_n(rst_n), .tdi(tdi),
    .cap_en(cap), .shf_en(shf), .upd_en(upd), .status_in(st2), .ir_so(so2),
    .instr(ins2), .reg_sel(sel2), .bs_mode(md2));
  tap_instr_reg #(.IR_W(4), .HAS_ID(1'b1)) u_wide (.tck(clk), .trst_n(rst_n), .tdi(tdi),
    .cap_en(cap), .shf_en(shf), .upd_en(upd), .status_in(st4), .ir_so(so4),
    .instr(ins4), .reg_sel(sel4), .bs_mode(md4));
  tap_instr_reg #(.IR_W(2), .HAS_ID(1'b0)) u_noid (.tck(clk), .trst_n(rst_n), .tdi(tdi),
    .cap_en(cap), .shf_en(shf), .upd_en(upd), .status_in(st2), .ir_so(son),
    .instr(insn), .reg_sel(seln), .bs_mode(mdn));

  // {code[1:0], sel[1:0], mode}
  localparam logic [4:0] VEC [4] = '{
    {2'b00, 2'b01, 1'b1},   // R5 external test
    {2'b01, 2'b10, 1'b0},   // R7 identification
    {2'b10, 2'b01, 1'b0},   // R6 sample/preload
    {2'b11, 2'b00, 1'b0}    // R8 bypass
  };
  // {code[3:0], sel[1:0], mode}
  localparam logic [6:0] WVEC [6] = '{
    {4'b0000, 2'b01, 1'b1}, {4'b0001, 2'b10, 1'b0}, {4'b0010, 2'b01, 1'b0},
    {4'b1111, 2'b00, 1'b0}, {4'b0101, 2'b00, 1'b0}, {4'b1000, 2'b00, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic load(input logic [3:0] code, input int n);
    cap = 1'b1; tick; cap = 1'b0;
    shf = 1'b1;
    for (int i = 0; i < n; i++) begin tdi = code[i]; tick; end
    shf = 1'b0;
    upd = 1'b1; tick; upd = 1'b0;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    nerr++;
    $display("FAIL watchdog: actual hung expected done");
    finish_up();
  end

  initial begin
    #5;
    chk("R1 reset instr", 8'(ins2), 8'h01);
    chk("R1 reset sel", 8'(sel2), 8'h02);
    chk("R1 reset wide instr", 8'(ins4), 8'h01);
    rst_n = 1'b1;
    tick;
    chk("R1 after release", 8'(ins2), 8'h01);

    for (int v = 0; v < 4; v++) begin
      load({2'b00, VEC[v][4:3]}, 2);
      chk("R5/R6/R7/R8 instr", 8'(ins2), 8'(VEC[v][4:3]));
      chk("R5/R6/R7/R8 sel", 8'(sel2), 8'(VEC[v][2:1]));
      chk("R5 mode", 8'(md2), 8'(VEC[v][0]));
      if (VEC[v][4:3] == 2'b01) chk("R7 no id gives bypass", 8'(seln), 8'h00);
    end

    for (int v = 0; v < 6; v++) begin
      load(WVEC[v][6:3], 4);
      chk("R8 wide instr", 8'(ins4), 8'(WVEC[v][6:3]));
      chk("R8 wide sel", 8'(sel4), 8'(WVEC[v][2:1]));
      chk("R5 wide mode", 8'(md4), 8'(WVEC[v][0]));
    end

    // R2/R3: capture status 1010 -> stage 1001, out 1,0,0,1
    st4 = 4'b1010; st2 = 2'b10;
    cap = 1'b1; tick; cap = 1'b0;
    chk("R2 wide bit0", 8'(so4), 8'h1);
    chk("R2 status low ignored", 8'(so2), 8'h1);
    shf = 1'b1; tdi = 1'b0;
    tick; chk("R3 wide bit1", 8'(so4), 8'h0); chk("R3 narrow bit1", 8'(so2), 8'h0);
    tick; chk("R2 wide bit2", 8'(so4), 8'h0);
    tick; chk("R2 wide status bit3", 8'(so4), 8'h1);
    shf = 1'b0;
    chk("R4 capture keeps instr", 8'(ins4), 8'h08);

    // R4: load external test, shift ones without update
    load(4'b0000, 2);
    shf = 1'b1; tdi = 1'b1; tick; tick; shf = 1'b0;
    chk("R4 shift keeps instr", 8'(ins2), 8'h00);
    chk("R4 shift keeps mode", 8'(md2), 8'h1);
    upd = 1'b1; tick; upd = 1'b0;
    chk("R4 update takes value", 8'(ins2), 8'h03);

    // R9: stage to 00 then capture+shift together
    shf = 1'b1; tdi = 1'b0; tick; tick; shf = 1'b0;
    chk("R9 pre stage", 8'(so2), 8'h0);
    cap = 1'b1; shf = 1'b1; tick; cap = 1'b0; shf = 1'b0;
    chk("R9 capture wins", 8'(so2), 8'h1);
    upd = 1'b1; tick; upd = 1'b0;
    chk("R9 updated code", 8'(ins2), 8'h01);

    // R1 mid-run reset
    load(4'b1111, 4);
    chk("R8 pre reset", 8'(ins4), 8'h0F);
    #1 rst_n = 1'b0; #1;
    chk("R1 async reset", 8'(ins4), 8'h01);
    chk("R1 async reset narrow", 8'(ins2), 8'h01);
    rst_n = 1'b1;
    tick;
    chk("R1 sel after reset", 8'(sel4), 8'h02);

    finish_up();
  end
endmodule